// File: doc/BRIEF.md
# Local Interrupt Vector Dispatcher

This block holds the per-processor table of local interrupt entries, with one 32-bit entry for each local source. The sources are a timer, two external interrupt lines and a few on-chip causes. When a source fires, the block reads that source's entry and turns it into a single request on exactly one output. The output is a system-management request, a non-maskable request, a request for the legacy interrupt controller to supply the vector, or a fixed vector that carries an edge or level trigger flag. A timer expiry is just another source index, so it goes through the same dispatch path as every other source.

The block also contains the acceptance gate for the legacy interrupt controller's request line. A rising edge on that line is accepted when the controller's global enable is off, or when the first external line's entry is unmasked. An accepted edge is dispatched through that entry. Each processor carries its own instance, and all instances see the same legacy request line. A processor with ID zero comes out of reset ready to pass legacy interrupts through. Every other processor comes out of reset with all of its entries masked.

Top module: `lvec_dispatch`

## Requirements
- R1: After reset, every entry holds 0x0001_0000 (masked). The one exception is the entry at index LINT0_IDX (default 3) on an instance with PROC_ID 0, which holds 0x0000_0700 (external-interrupt mode, unmasked).
- R2: An event whose entry has bit 16 (mask) set produces no output strobe of any kind.
- R3: The delivery mode is entry bits 10:8. The value 3'b000 gives a fixed interrupt, 3'b010 gives smi_req, 3'b100 gives nmi_req and 3'b111 gives extint_req. The other four codes, and a source index of NUM_SRC or above, give no output.
- R4: A fixed interrupt drives fix_vec with entry bits 7:0.
- R5: fix_level is 1 only when the source is LINT0_IDX or LINT1_IDX (default 4) and entry bit 15 is set. Otherwise a fixed interrupt is edge (fix_level 0).
- R6: An event sampled at a clock edge shows its strobe in the following cycle. At most one strobe is high, and it lasts one cycle.
- R7: A table write takes effect for events sampled on the next edge. An event sampled on the same edge as the write uses the old entry.
- R8: pic_accept is 1 exactly when glb_en is 0 or bit 16 of the LINT0 entry is 0.
- R9: A rising edge of pic_req, while pic_accept is 1, is dispatched through the LINT0 entry. A held-high or low pic_req dispatches nothing, and neither does an edge that arrives while pic_accept is 0.
- R10: When an accepted pic_req edge and src_fire are sampled on the same edge, only the LINT0 dispatch is made and the src_fire event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_data | input | 32 | Entry value to write |
| glb_en | input | 1 | Controller global enable |
| src_fire | input | 1 | Local source event strobe |
| src_idx | input | IDX_W | Index of the firing source (0 is the timer) |
| pic_req | input | 1 | Legacy controller request level |
| pic_accept | output | 1 | Legacy request currently accepted on LINT0 |
| smi_req | output | 1 | System-management request strobe |
| nmi_req | output | 1 | Non-maskable request strobe |
| extint_req | output | 1 | Strobe asking the legacy controller for the vector |
| fix_req | output | 1 | Fixed interrupt strobe |
| fix_vec | output | 8 | Vector of the fixed interrupt |
| fix_level | output | 1 | Fixed interrupt is level-triggered |

## Verification
The strobes and fix_vec/fix_level are registered once, so they are due in the cycle after the edge that samples src_fire or the first high pic_req. pic_accept is combinational on glb_en and the stored LINT0 entry, so it is due as soon as a write lands. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. It checks every event there, and checks one cycle later that the strobe has dropped. The write-timing checks place the write and the event on the same edge and then on consecutive edges, which separates the old entry value from the new one.

// File: rtl/lvec_pkg.sv
package lvec_pkg;

   localparam int ENTRY_W   = 32;
   localparam int VEC_W     = 8;
   localparam int MASK_BIT  = 16;
   localparam int LEVEL_BIT = 15;
   localparam int MODE_LSB  = 8;

   // delivery mode codes in bits 10:8
   localparam logic [2:0] DM_FIXED  = 3'b000;
   localparam logic [2:0] DM_SMI    = 3'b010;
   localparam logic [2:0] DM_NMI    = 3'b100;
   localparam logic [2:0] DM_EXTINT = 3'b111;

   // the fields of an entry that the dispatch path uses
   typedef struct packed {
      logic             masked;
      logic             level;
      logic [2:0]       mode;
      logic [VEC_W-1:0] vec;
   } lvt_ent_t;

   typedef struct packed {
      logic             smi;
      logic             nmi;
      logic             ext;
      logic             fix;
      logic             level;
      logic [VEC_W-1:0] vec;
   } lvt_req_t;

   function automatic lvt_ent_t ent_unpack(input logic [ENTRY_W-1:0] w);
      lvt_ent_t e;
      e.masked = w[MASK_BIT];
      e.level  = w[LEVEL_BIT];
      e.mode   = w[MODE_LSB +: 3];
      e.vec    = w[VEC_W-1:0];
      return e;
   endfunction

   localparam logic [ENTRY_W-1:0] RST_WORD_EXTINT = 32'h0000_0700;
   localparam logic [ENTRY_W-1:0] RST_WORD_MASKED = 32'h0001_0000;

endpackage

// File: rtl/lvec_table.sv
module lvec_table
   import lvec_pkg::*;
#(
   parameter int NUM_SRC   = 6,
   parameter int IDX_W     = 3,
   parameter int LINT0_IDX = 3,
   parameter int PROC_ID   = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output lvt_ent_t           rd_ent,
   output logic               rd_hit,
   output lvt_ent_t           lint0_ent
);

   lvt_ent_t ent_q [NUM_SRC];
   lvt_ent_t wr_ent;

   assign wr_ent = ent_unpack(wr_data);

   // reserved bits are not stored
   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[ENTRY_W-1:MASK_BIT+1], wr_data[LEVEL_BIT-1:MODE_LSB+3]};

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
      localparam logic [ENTRY_W-1:0] RST_WORD =
         (g == LINT0_IDX && PROC_ID == 0) ? RST_WORD_EXTINT : RST_WORD_MASKED;
      localparam lvt_ent_t RST_ENT = ent_unpack(RST_WORD);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q[g] <= RST_ENT;
         else if (wr_en && wr_idx == IDX_W'(g))
            ent_q[g] <= wr_ent;
      end
   end

   always_comb begin
      rd_ent = '0;
      rd_hit = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_ent = ent_q[i];
            rd_hit = 1'b1;
         end
      end
   end

   assign lint0_ent = ent_q[LINT0_IDX];

   // R7
   wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(LINT0_IDX)) |=> (lint0_ent == $past(wr_ent)));

endmodule

// File: rtl/lvec_pic_gate.sv
module lvec_pic_gate
   import lvec_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pic_req,
   input  logic     glb_en,
   input  lvt_ent_t lint0_ent,
   output logic     pic_accept,
   output logic     pic_evt
);

   logic pic_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pic_q <= 1'b0;
      else        pic_q <= pic_req;
   end

   assign pic_accept = !glb_en || !lint0_ent.masked;
   assign pic_evt    = pic_req && !pic_q && pic_accept;

   // R9
   pic_single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pic_evt |=> !pic_evt);

endmodule

// File: rtl/lvec_decode.sv
module lvec_decode
   import lvec_pkg::*;
#(
   parameter int IDX_W     = 3,
   parameter int LINT0_IDX = 3,
   parameter int LINT1_IDX = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_valid,
   input  logic [IDX_W-1:0] evt_idx,
   input  lvt_ent_t         ent,
   output lvt_req_t         req_q
);

   lvt_req_t req_d;
   logic     lvl_ok;

   assign lvl_ok = (evt_idx == IDX_W'(LINT0_IDX)) || (evt_idx == IDX_W'(LINT1_IDX));

   always_comb begin
      req_d = '0;
      if (evt_valid && !ent.masked) begin
         case (ent.mode)
            DM_SMI:    req_d.smi = 1'b1;
            DM_NMI:    req_d.nmi = 1'b1;
            DM_EXTINT: req_d.ext = 1'b1;
            DM_FIXED: begin
               req_d.fix   = 1'b1;
               req_d.vec   = ent.vec;
               req_d.level = lvl_ok && ent.level;
            end
            default: req_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_d;
   end

   // R6
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_q.smi, req_q.nmi, req_q.ext, req_q.fix}));

   // R6
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid == 1'b0) |=> !(req_q.smi || req_q.nmi || req_q.ext || req_q.fix));

   // R2
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && ent.masked) |=> !(req_q.smi || req_q.nmi || req_q.ext || req_q.fix));

   // R5
   level_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !lvl_ok) |=> !req_q.level);

   // R4
   fix_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !ent.masked && ent.mode == DM_FIXED) |=> (req_q.fix && req_q.vec == $past(ent.vec)));

endmodule

// File: rtl/lvec_dispatch.sv
module lvec_dispatch
   import lvec_pkg::*;
#(
   parameter int NUM_SRC   = 6,
   parameter int LINT0_IDX = 3,
   parameter int LINT1_IDX = 4,
   parameter int PROC_ID   = 0,
   localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic               glb_en,
   input  logic               src_fire,
   input  logic [IDX_W-1:0]   src_idx,
   input  logic               pic_req,
   output logic               pic_accept,
   output logic               smi_req,
   output logic               nmi_req,
   output logic               extint_req,
   output logic               fix_req,
   output logic [VEC_W-1:0]   fix_vec,
   output logic               fix_level
);

   if (NUM_SRC < 3) begin : g_bad_num
      $error("lvec_dispatch: NUM_SRC must be at least 3");
   end
   if (LINT0_IDX >= NUM_SRC || LINT1_IDX >= NUM_SRC || LINT0_IDX == LINT1_IDX) begin : g_bad_lint
      $error("lvec_dispatch: LINT indices must be distinct and below NUM_SRC");
   end
   if (LINT0_IDX == 0 || LINT1_IDX == 0) begin : g_bad_timer
      $error("lvec_dispatch: index 0 is reserved for the timer");
   end

   lvt_ent_t         rd_ent, lint0_ent;
   logic             rd_hit, pic_evt, evt_valid;
   logic [IDX_W-1:0] evt_idx;
   lvt_req_t         req_q;

   // an accepted legacy edge owns the dispatch lane for its cycle
   assign evt_idx   = pic_evt ? IDX_W'(LINT0_IDX) : src_idx;
   assign evt_valid = pic_evt || (src_fire && rd_hit);

   lvec_table #(
      .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .LINT0_IDX(LINT0_IDX), .PROC_ID(PROC_ID)
   ) table_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(evt_idx), .rd_ent(rd_ent), .rd_hit(rd_hit), .lint0_ent(lint0_ent)
   );

   lvec_pic_gate gate_i (
      .clk(clk), .rst_n(rst_n), .pic_req(pic_req), .glb_en(glb_en),
      .lint0_ent(lint0_ent), .pic_accept(pic_accept), .pic_evt(pic_evt)
   );

   lvec_decode #(
      .IDX_W(IDX_W), .LINT0_IDX(LINT0_IDX), .LINT1_IDX(LINT1_IDX)
   ) decode_i (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
      .ent(rd_ent), .req_q(req_q)
   );

   assign smi_req    = req_q.smi;
   assign nmi_req    = req_q.nmi;
   assign extint_req = req_q.ext;
   assign fix_req    = req_q.fix;
   assign fix_vec    = req_q.vec;
   assign fix_level  = req_q.level;

   // R10
   pic_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pic_evt && !lint0_ent.masked && lint0_ent.mode == DM_NMI) |=> (nmi_req && !smi_req && !fix_req));

endmodule

// File: tb/lvec_dispatch_tb.sv
module lvec_dispatch_tb_top;

   localparam int IDX_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [IDX_W-1:0]  wr_idx = '0;
   logic [31:0]       wr_data = '0;
   logic              glb_en = 1'b1;
   logic              src_fire = 1'b0;
   logic [IDX_W-1:0]  src_idx = '0;
   logic              pic_req = 1'b0;

   logic       acc0, smi0, nmi0, ext0, fix0, lvl0;
   logic [7:0] vec0;
   logic       acc1, smi1, nmi1, ext1, fix1, lvl1;
   logic [7:0] vec1;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10ns clk = ~clk;

   lvec_dispatch #(.PROC_ID(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .glb_en(glb_en), .src_fire(src_fire), .src_idx(src_idx), .pic_req(pic_req),
      .pic_accept(acc0), .smi_req(smi0), .nmi_req(nmi0), .extint_req(ext0),
      .fix_req(fix0), .fix_vec(vec0), .fix_level(lvl0)
   );

   lvec_dispatch #(.PROC_ID(1)) dut_p1_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .glb_en(glb_en), .src_fire(src_fire), .src_idx(src_idx), .pic_req(pic_req),
      .pic_accept(acc1), .smi_req(smi1), .nmi_req(nmi1), .extint_req(ext1),
      .fix_req(fix1), .fix_vec(vec1), .fix_level(lvl1)
   );

   // packed view: {smi, nmi, ext, fix, level, vec}
   function automatic logic [12:0] pk(logic s, logic n, logic e, logic f, logic l, logic [7:0] v);
      return {s, n, e, f, l, v};
   endfunction

   localparam logic [12:0] NONE = 13'h0;

   task automatic chk(string req, logic [12:0] act, logic [12:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_bit(string req, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic write_ent(int idx, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // fire one source and check processor 0's strobe and that it drops (R6)
   task automatic fire_chk(string req, int idx, logic [12:0] exp);
      @(negedge clk);
      src_fire = 1'b1; src_idx = IDX_W'(idx);
      @(negedge clk);
      src_fire = 1'b0;
      chk(req, pk(smi0, nmi0, ext0, fix0, lvl0, vec0), exp);
      @(negedge clk);
      chk("R6 strobe drops", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), NONE);
   endtask

   task automatic t_reset();
      chk("R1 outputs idle after reset", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), NONE);
      chk_bit("R8 accept on cpu0 after reset", acc0, 1'b1);
      chk_bit("R8 no accept on cpu1 after reset", acc1, 1'b0);
      fire_chk("R1 timer masked at reset", 0, NONE);
      // LINT0 on both instances
      @(negedge clk);
      src_fire = 1'b1; src_idx = 3'd3;
      @(negedge clk);
      src_fire = 1'b0;
      chk("R1 cpu0 LINT0 is extint", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), pk(0,0,1,0,0,8'h0));
      chk("R1 cpu1 LINT0 masked", pk(smi1, nmi1, ext1, fix1, lvl1, vec1), NONE);
      // legacy edge: cpu0 accepts, cpu1 does not (R9)
      @(negedge clk);
      pic_req = 1'b1;
      @(negedge clk);
      chk("R9 cpu0 takes pic edge", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), pk(0,0,1,0,0,8'h0));
      chk("R9 cpu1 refuses pic edge", pk(smi1, nmi1, ext1, fix1, lvl1, vec1), NONE);
      @(negedge clk);
      chk("R9 held high gives nothing", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), NONE);
      pic_req = 1'b0;
      @(negedge clk);
      chk("R9 low gives nothing", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), NONE);
   endtask

   task automatic t_modes();
      write_ent(0, 32'h0000_0041);
      fire_chk("R4 timer fixed vec 41", 0, pk(0,0,0,1,0,8'h41));
      write_ent(0, 32'h0000_02C3);
      fire_chk("R3 mode 010 is smi", 0, pk(1,0,0,0,0,8'h0));
      write_ent(0, 32'h0000_0400);
      fire_chk("R3 mode 100 is nmi", 0, pk(0,1,0,0,0,8'h0));
      write_ent(0, 32'h0000_0700);
      fire_chk("R3 mode 111 is extint", 0, pk(0,0,1,0,0,8'h0));
      write_ent(0, 32'h0000_0155);
      fire_chk("R3 mode 001 dropped", 0, NONE);
      write_ent(0, 32'h0000_0355);
      fire_chk("R3 mode 011 dropped", 0, NONE);
      write_ent(0, 32'h0000_0555);
      fire_chk("R3 mode 101 dropped", 0, NONE);
      write_ent(0, 32'h0000_0655);
      fire_chk("R3 mode 110 dropped", 0, NONE);
      fire_chk("R3 index out of range dropped", 6, NONE);
      write_ent(2, 32'h0000_00E7);
      fire_chk("R4 source 2 fixed vec e7", 2, pk(0,0,0,1,0,8'hE7));
   endtask

   task automatic t_mask();
      write_ent(0, 32'h0001_0041);
      fire_chk("R2 masked fixed silent", 0, NONE);
      write_ent(0, 32'h0001_0200);
      fire_chk("R2 masked smi silent", 0, NONE);
      write_ent(0, 32'h0001_0700);
      fire_chk("R2 masked extint silent", 0, NONE);
   endtask

   task automatic t_level();
      write_ent(0, 32'h0000_8055);
      fire_chk("R5 timer level bit ignored", 0, pk(0,0,0,1,0,8'h55));
      write_ent(4, 32'h0000_8066);
      fire_chk("R5 LINT1 level", 4, pk(0,0,0,1,1,8'h66));
      write_ent(3, 32'h0000_8077);
      fire_chk("R5 LINT0 level", 3, pk(0,0,0,1,1,8'h77));
      write_ent(4, 32'h0000_0066);
      fire_chk("R5 LINT1 edge", 4, pk(0,0,0,1,0,8'h66));
   endtask

   task automatic t_wr_timing();
      write_ent(1, 32'h0000_0011);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'd1; wr_data = 32'h0000_0022;
      src_fire = 1'b1; src_idx = 3'd1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 same-edge event uses old entry", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), pk(0,0,0,1,0,8'h11));
      @(negedge clk);
      src_fire = 1'b0;
      chk("R7 next-edge event uses new entry", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), pk(0,0,0,1,0,8'h22));
      @(negedge clk);
   endtask

   task automatic t_pic();
      write_ent(3, 32'h0001_0700);
      glb_en = 1'b1;
      @(negedge clk);
      chk_bit("R8 masked and enabled refuses", acc0, 1'b0);
      pic_req = 1'b1;
      @(negedge clk);
      chk("R9 refused edge gives nothing", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), NONE);
      pic_req = 1'b0;
      glb_en = 1'b0;
      @(negedge clk);
      chk_bit("R8 global disable accepts", acc0, 1'b1);
      pic_req = 1'b1;
      @(negedge clk);
      chk("R9 accepted but masked entry silent", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), NONE);
      pic_req = 1'b0;
      glb_en = 1'b1;
      write_ent(3, 32'h0000_8090);
      chk_bit("R8 unmasked accepts", acc0, 1'b1);
      @(negedge clk);
      pic_req = 1'b1;
      @(negedge clk);
      chk("R9 edge through fixed LINT0", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), pk(0,0,0,1,1,8'h90));
      pic_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_prio();
      write_ent(3, 32'h0000_0400);
      write_ent(0, 32'h0000_0200);
      @(negedge clk);
      pic_req = 1'b1; src_fire = 1'b1; src_idx = 3'd0;
      @(negedge clk);
      src_fire = 1'b0;
      chk("R10 pic edge wins over src_fire", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), pk(0,1,0,0,0,8'h0));
      @(negedge clk);
      chk("R10 dropped event not replayed", pk(smi0, nmi0, ext0, fix0, lvl0, vec0), NONE);
      pic_req = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_mask();
      t_level();
      t_wr_timing();
      t_pic();
      t_prio();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule